// File: doc/BRIEF.md
# Two-Stage Cascaded Pacer Clock

The block produces a periodic pacer strobe for data-acquisition sampling. It chains two 16-bit down-counters, and each one runs as a periodic rate divider. The first stage counts every input clock. Its terminal-count pulse is the count enable of the second stage. The output period is therefore the product of the two divisors, in input clock cycles, so a span of up to 32 bits is reached with two small counters.

Software stages divisors in a pending register pair and makes them active with an explicit update strobe. When `enable_i` is asserted, the block programs both stages into periodic mode. It then loads the second stage one cycle before the first, so the first stage can never reach terminal count against a second stage that has not been loaded. When `enable_i` is deasserted, both stages fall back to a non-periodic idle mode and nothing is loaded. While the pair is running it is reported busy. An update strobe issued during that time is held back until the next enable, so the active divisors never change within a running period.

Top module: `pacer_cascade`

## Requirements
- R1: While running, `pacer_no` is low for exactly one clock cycle, and successive low cycles are d1·d2 cycles apart, where d1 and d2 are the active first- and second-stage divisors.
- R2: If `enable_i` is first sampled high on rising edge 1, the first low cycle of `pacer_no` follows rising edge d1·d2+3.
- R3: On enable, `load_o` shows 2'b10 (bit 1 = second stage loaded) in the first cycle and 2'b01 (bit 0 = first stage loaded) in the next cycle. The first stage is never loaded unless the second stage was loaded in the cycle before.
- R4: One edge after `enable_i` is sampled low, `periodic_o` is 2'b00, `busy_o` is 0, `pacer_no` is 1 and `load_o` is 2'b00. This state holds for as long as `enable_i` stays low.
- R5: A divisor write (`div_wr_i` bit 0 = first stage, bit 1 = second stage, value on `div_data_i`) changes only the pending value. The running period follows it only after `div_update_i` is pulsed.
- R6: An update pulse received while `busy_o` is high has no effect on the running period. The pending divisors become active at the next enable.
- R7: A divisor write with a value below 2 or above 65536 is ignored, and the pending value is kept.
- R8: A divisor of 65536 is accepted and divides by 65536.
- R9: After reset, `busy_o` is 0, `pacer_no` is 1, `periodic_o` is 2'b00, and both active and pending divisors are 2.
- R10: `busy_o` and both bits of `periodic_o` are high from the first cycle after enable is sampled until the cycle after it is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_wr_i | input | 2 | Pending divisor write strobes (bit 0 first stage, bit 1 second stage) |
| div_data_i | input | 17 | Divisor value, 2 to 65536 |
| div_update_i | input | 1 | Moves the pending divisors into the active pair |
| enable_i | input | 1 | Runs the pacer while high |
| pacer_no | output | 1 | Pacer strobe, one-cycle low pulse |
| busy_o | output | 1 | The stages are owned by the running pacer |
| periodic_o | output | 2 | Per-stage mode: 1 periodic, 0 idle |
| load_o | output | 2 | Per-stage load strobe (bit 0 first stage, bit 1 second stage) |

## Verification
The hardest case to reach is an update strobe that arrives in the middle of a running period, followed by the deferred transfer at the next enable. The bench starts the pacer with small divisors and stages different pending values while it runs. It pulses the update and measures a full period to show the old product still holds. It then disables, re-enables, and measures both first-pulse latency and period against the new product. The 65536 case is reached by pairing it with a divisor of 2, so that a single latency measurement stays short.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD2 = 2'd1,
    ST_LOAD1 = 2'd2,
    ST_RUN   = 2'd3
  } pacer_state_e;
endpackage

// File: rtl/pacer_div_regs.sv
module pacer_div_regs #(
  parameter int W       = 16,
  parameter int NSTAGE  = 2,
  parameter int DEF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSTAGE-1:0] wr_i,
  input  logic [W:0]        data_i,
  input  logic              update_i,
  input  logic              start_i,
  input  logic              running_i,
  output logic [W-1:0]      act_o [NSTAGE]
);
  localparam logic [W:0] DMIN = (W+1)'(2);
  localparam logic [W:0] DMAX = {1'b1, {W{1'b0}}};

  logic [W-1:0] pend_q [NSTAGE];
  logic [W-1:0] act_q  [NSTAGE];
  logic         defer_q;
  logic         valid;
  logic         xfer;

  assign valid = (data_i >= DMIN) && (data_i <= DMAX);
  assign xfer  = (update_i && !running_i) || (start_i && defer_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) defer_q <= 1'b0;
    else if (start_i) defer_q <= 1'b0;
    else if (update_i && running_i) defer_q <= 1'b1;
  end

  for (genvar i = 0; i < NSTAGE; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[i] <= W'(DEF_DIV);
        act_q[i]  <= W'(DEF_DIV);
      end else begin
        if (wr_i[i] && valid) pend_q[i] <= data_i[W-1:0]; // 65536 -> 0
        if (xfer) act_q[i] <= pend_q[i];
      end
    end
    assign act_o[i] = act_q[i];
  end
endmodule

// File: rtl/pacer_stage.sv
module pacer_stage #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         run_i,
  input  logic         ce_i,
  input  logic [W-1:0] div_i,
  output logic         tc_o
);
  logic [W-1:0] cnt_q;
  logic         at_one;

  assign at_one = (cnt_q == W'(1));
  assign tc_o   = run_i && ce_i && at_one;

  // zero decrements through all-ones, giving a 2^W divide
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= div_i;
    else if (run_i && ce_i) cnt_q <= at_one ? div_i : cnt_q - W'(1);
  end
endmodule

// File: rtl/pacer_cascade.sv
module pacer_cascade
  import pacer_pkg::*;
#(
  parameter int W       = 16,
  parameter int DEF_DIV = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   div_wr_i,
  input  logic [W:0]   div_data_i,
  input  logic         div_update_i,
  input  logic         enable_i,
  output logic         pacer_no,
  output logic         busy_o,
  output logic [1:0]   periodic_o,
  output logic [1:0]   load_o
);
  localparam int NSTAGE = 2;

  pacer_state_e state_q, state_d;
  logic [W-1:0] act [NSTAGE];
  logic [NSTAGE-1:0] tc, ce, ld;
  logic start, run;

  assign start = (state_q == ST_IDLE) && enable_i;
  assign run   = (state_q == ST_RUN);

  always_comb begin
    state_d = state_q;
    if (!enable_i) state_d = ST_IDLE;
    else begin
      case (state_q)
        ST_IDLE:  state_d = ST_LOAD2;
        ST_LOAD2: state_d = ST_LOAD1;
        ST_LOAD1: state_d = ST_RUN;
        default:  state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else state_q <= state_d;
  end

  pacer_div_regs #(.W(W), .NSTAGE(NSTAGE), .DEF_DIV(DEF_DIV)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (div_wr_i),
    .data_i   (div_data_i),
    .update_i (div_update_i),
    .start_i  (start),
    .running_i(state_q != ST_IDLE),
    .act_o    (act)
  );

  assign ld[0] = (state_q == ST_LOAD1);
  assign ld[1] = (state_q == ST_LOAD2);
  assign ce[0] = 1'b1;

  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    if (i > 0) begin : g_chain
      assign ce[i] = tc[i-1];
    end
    pacer_stage #(.W(W)) u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(ld[i]),
      .run_i (run),
      .ce_i  (ce[i]),
      .div_i (act[i]),
      .tc_o  (tc[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pacer_no <= 1'b1;
    else pacer_no <= !(tc[NSTAGE-1] && enable_i);
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign periodic_o = {NSTAGE{busy_o}};
  assign load_o     = ld;
endmodule

// File: rtl/pacer_chk.sv
module pacer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       enable_i,
  input logic       pacer_no,
  input logic       busy_o,
  input logic [1:0] periodic_o,
  input logic [1:0] load_o
);
  // R1: pulse is a single cycle
  a_r1_one_cycle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pacer_no |=> pacer_no);
  // R3: first stage loads only right after the second stage
  a_r3_load_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o[0] |-> $past(load_o[1]));
  a_r3_start_second: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (load_o == 2'b10));
  // R4: disable forces idle mode
  a_r4_idle_on_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (periodic_o == 2'b00 && pacer_no && load_o == 2'b00 && !busy_o));
  // R10: no strobe while not owned
  a_r10_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> pacer_no);
  a_r10_mode_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (periodic_o == 2'b11));
endmodule

bind pacer_cascade pacer_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .enable_i  (enable_i),
  .pacer_no  (pacer_no),
  .busy_o    (busy_o),
  .periodic_o(periodic_o),
  .load_o    (load_o)
);

// File: tb/pacer_cascade_bench.sv
module pacer_cascade_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  div_wr_i = 2'b00;
  logic [16:0] div_data_i = '0;
  logic        div_update_i = 1'b0;
  logic        enable_i = 1'b0;
  logic        pacer_no, busy_o;
  logic [1:0]  periodic_o, load_o;

  int checks = 0;
  int fails = 0;

  always #10 clk_i = ~clk_i;

  pacer_cascade u_pacer_cascade (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_wr_i(div_wr_i), .div_data_i(div_data_i),
    .div_update_i(div_update_i), .enable_i(enable_i), .pacer_no(pacer_no),
    .busy_o(busy_o), .periodic_o(periodic_o), .load_o(load_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_div(input logic [1:0] which, input int val);
    div_wr_i = which; div_data_i = 17'(val);
    @(negedge clk_i);
    div_wr_i = 2'b00;
  endtask

  task automatic pulse_update();
    div_update_i = 1'b1;
    @(negedge clk_i);
    div_update_i = 1'b0;
  endtask

  task automatic wait_low(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (pacer_no && n < 140000);
  endtask

  // enable, measure latency, width and one period
  task automatic run_measure(input string req, input int prod, input bit do_period);
    int n;
    enable_i = 1'b1;
    wait_low(n);
    chk({req, " latency"}, n, prod + 3);
    if (do_period) begin
      @(negedge clk_i);
      chk({req, " width"}, int'(pacer_no), 1);
      wait_low(n);
      chk({req, " period"}, n + 1, prod);
    end
  endtask

  task automatic stop();
    enable_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R9 busy", int'(busy_o), 0);
    chk("R9 pacer", int'(pacer_no), 1);
    chk("R9 mode", int'(periodic_o), 0);
    run_measure("R9 default divisors", 4, 1'b1);
    stop();
  endtask

  task automatic t_load_order();
    wr_div(2'b01, 3); wr_div(2'b10, 5); pulse_update();
    enable_i = 1'b1;
    @(negedge clk_i);
    chk("R3 second first", int'(load_o), 2);
    chk("R10 busy", int'(busy_o), 1);
    chk("R10 mode", int'(periodic_o), 3);
    @(negedge clk_i);
    chk("R3 first next", int'(load_o), 1);
    @(negedge clk_i);
    chk("R3 done", int'(load_o), 0);
    stop();
    run_measure("R1 R2 3x5", 15, 1'b1);
    enable_i = 1'b0;
    @(negedge clk_i);
    chk("R4 mode", int'(periodic_o), 0);
    chk("R4 busy", int'(busy_o), 0);
    chk("R4 load", int'(load_o), 0);
    repeat (40) begin
      @(negedge clk_i);
      if (!pacer_no) chk("R4 no strobe while idle", 0, 1);
    end
    chk("R4 pacer high", int'(pacer_no), 1);
  endtask

  task automatic t_no_update();
    wr_div(2'b01, 7); wr_div(2'b10, 7);
    run_measure("R5 write without update", 15, 1'b1);
    stop();
    pulse_update();
    run_measure("R5 after update", 49, 1'b0);
    stop();
  endtask

  task automatic t_deferred();
    int n;
    wr_div(2'b01, 2); wr_div(2'b10, 3); pulse_update();
    enable_i = 1'b1;
    wait_low(n);
    wr_div(2'b01, 5); wr_div(2'b10, 4);
    pulse_update();
    wait_low(n);
    wait_low(n);
    chk("R6 period unchanged", n, 6);
    stop();
    run_measure("R6 applied at enable", 20, 1'b1);
    stop();
  endtask

  task automatic t_range();
    wr_div(2'b01, 1); wr_div(2'b10, 0); wr_div(2'b11, 65537);
    pulse_update();
    run_measure("R7 bad values ignored", 20, 1'b0);
    stop();
  endtask

  task automatic t_max();
    wr_div(2'b01, 65536); wr_div(2'b10, 2); pulse_update();
    run_measure("R8 65536", 131072, 1'b0);
    stop();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_load_order();
    t_no_update();
    t_deferred();
    t_range();
    t_max();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule